// File: doc/BRIEF.md
# Two-Stage Baud Rate Generator

This block makes the bit-rate strobe for an asynchronous serial port. A source event stream is either every cycle of the system clock or every rising edge of an external clock pin, depending on a select input. The stream first passes through a power-of-two prescaler set by a 3-bit code `n`. It then passes through a 5-bit programmable counter that wraps after `k + 16` steps, where `k` is a 4-bit code. A final halving stage completes the division. The resulting rate is the source frequency divided by 2^(n+1) × (k+16).

The external pin is synchronised into the system clock domain, and only its rising edges count. A new prescale code, divisor code or source select is taken up only at the end of a complete baud period, so a period is never cut short. The divisor code 15 is prohibited. While it is applied, the block raises an error flag and issues no strobes.

Top module: `baud_gen`

## Requirements
- R1: While reset is asserted and after its release with enable low, `tick_o` and `cfg_err_o` are 0.
- R2: With the system clock as source (`src_sel_i` = 0), successive `tick_o` pulses are exactly 2^(n+1) × (k+16) clock cycles apart, for `n` = `presc_i` in 0..7 and `k` = `div_i` in 0..14.
- R3: When `en_i` is first sampled high at a clock edge, the first `tick_o` pulse is visible after the edge that lies one full period later, with that first edge counted as 1. This holds for system-clock source.
- R4: While `en_i` is low, no `tick_o` pulse occurs and the internal count returns to its start. After a later enable, the first pulse again comes one full period later.
- R5: `div_i` = 15 is prohibited. `cfg_err_o` is 1 from the clock edge after `div_i` becomes 15 until the edge after it leaves 15. While `div_i` is 15, no `tick_o` pulse occurs. A valid code restarts the count from zero.
- R6: With the external pin as source (`src_sel_i` = 1), the tick spacing is the pin period multiplied by 2^(n+1) × (k+16). While the pin does not toggle, no `tick_o` pulse occurs.
- R7: A change of `presc_i`, `div_i` or `src_sel_i` while running does not alter the period in progress. The new setting applies from the period that starts after the next `tick_o`.
- R8: Each `tick_o` pulse is exactly one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears the dividers |
| src_sel_i | input | 1 | 0: system clock source, 1: external pin source |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| presc_i | input | 3 | Prescale code n, divide by 2^n before the counter |
| div_i | input | 4 | Divisor code k, counter wraps at k+16; 15 is prohibited |
| tick_o | output | 1 | One-cycle baud strobe |
| cfg_err_o | output | 1 | Prohibited divisor code flag |

## Verification
The hardest case to reach from the ports is a setting change that arrives part-way through a period. It has to be shown that the period already running keeps its old length and the new length applies only to the period after it. The bench lines itself up on an observed strobe, waits a fixed number of cycles, and then writes a new divisor. It then measures two strobe spacings back to back and expects the old value for the first and the new value for the second. A second hard case is a restart after the prohibited code. Here the bench applies the valid code and the enable together, and checks that the first period runs at the new length.

// File: rtl/baud_pkg.sv
package baud_pkg;
  parameter int unsigned PRESC_W  = 3;
  parameter int unsigned DIV_W    = 4;
  parameter int unsigned CNT_W    = 5;
  parameter int unsigned DIV_BASE = 16;
  parameter int unsigned DIV_BAD  = 15;
  parameter int unsigned PCNT_W   = (1 << PRESC_W) - 1;

  typedef struct packed {
    logic               sel;
    logic [PRESC_W-1:0] n;
    logic [DIV_W-1:0]   k;
  } baud_cfg_t;
endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int unsigned N_W = PRESC_W,
  localparam int unsigned C_W = (1 << N_W) - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           evt_i,
  input  logic [N_W-1:0] n_i,
  output logic           pulse_o
);
  logic [C_W-1:0] cnt_q, cnt_d;
  logic [C_W-1:0] mask;

  always_comb begin
    mask    = (C_W'(1) << n_i) - C_W'(1);
    pulse_o = evt_i && ((cnt_q & mask) == mask);
    if (clr_i)      cnt_d = '0;
    else if (evt_i) cnt_d = cnt_q + C_W'(1);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_PULSE_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> evt_i); // R6
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] term_i,
  output logic         wrap_o,
  output logic         half_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         half_q, half_d;

  always_comb begin
    wrap_o = step_i && (cnt_q == term_i - W'(1));
    cnt_d  = cnt_q;
    half_d = half_q;
    if (clr_i) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (wrap_o) begin
      cnt_d  = '0;
      half_d = ~half_q;
    end else if (step_i) begin
      cnt_d  = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign half_o = half_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i != '0) |-> (cnt_q < term_i)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !half_q); // R4
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               src_sel_i,
  input  logic               ext_clk_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               tick_o,
  output logic               cfg_err_o
);
  logic      rs1_q, rst_q;
  logic      run, run_q;
  logic      bad;
  baud_cfg_t live, cfg_q, cfg_d, cfg_eff;
  logic      ext_rise, src_evt, presc_pulse, wrap, half, tick_d;
  logic [CNT_W-1:0] term;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_q <= rs1_q;
    end
  end

  baud_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .async_i(ext_clk_i),
    .rise_o (ext_rise)
  );

  always_comb begin
    live    = '{sel: src_sel_i, n: presc_i, k: div_i};
    bad     = (div_i == DIV_W'(DIV_BAD));
    run     = en_i && !bad;
    cfg_eff = run_q ? cfg_q : live;
    term    = CNT_W'(DIV_BASE) + CNT_W'(cfg_eff.k);
    src_evt = cfg_eff.sel ? ext_rise : 1'b1;
    tick_d  = wrap && half;
    cfg_d   = (!run || !run_q || tick_d) ? live : cfg_q;
  end

  baud_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .clr_i  (!run || tick_d),
    .evt_i  (src_evt && run),
    .n_i    (cfg_eff.n),
    .pulse_o(presc_pulse)
  );

  baud_divider u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .clr_i  (!run),
    .step_i (presc_pulse),
    .term_i (term),
    .wrap_o (wrap),
    .half_o (half)
  );

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      run_q     <= 1'b0;
      cfg_q     <= '0;
      tick_o    <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      run_q     <= run;
      cfg_q     <= cfg_d;
      tick_o    <= tick_d;
      cfg_err_o <= bad;
    end
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_q)
    tick_o |=> !tick_o); // R8
  AST_NO_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_q)
    !en_i |=> !tick_o); // R4
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_q)
    (div_i == DIV_W'(DIV_BAD)) |=> (!tick_o && cfg_err_o)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_q)
    (run && run_q && !tick_d) |=> $stable(cfg_q)); // R7
endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       sel = 1'b0;
  logic       ext = 1'b0;
  logic [2:0] presc = 3'd0;
  logic [3:0] div = 4'd0;
  logic       tick, err;
  logic       ext_run = 1'b0;
  int         ext_cnt = 0;
  int         checks = 0;
  int         errors = 0;
  logic       wd_fired = 1'b0;

  always #4 clk = ~clk;

  baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .src_sel_i(sel), .ext_clk_i(ext),
    .presc_i(presc), .div_i(div), .tick_o(tick), .cfg_err_o(err)
  );

  // external pin: period 6 system cycles while ext_run
  always @(negedge clk) begin
    if (ext_run) begin
      if (ext_cnt == 2) begin ext_cnt <= 0; ext <= ~ext; end
      else ext_cnt <= ext_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // from a negedge, count posedges until tick seen at a negedge; -1 on limit
  task automatic wait_tick(input int limit, output int cyc);
    cyc = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) begin cyc = i; break; end
    end
  endtask

  task automatic no_tick(input int len, output int seen);
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 tick in reset", int'(tick), 0);
    chk("R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 tick after reset", int'(tick), 0);
    chk("R1 err after reset", int'(err), 0);
  endtask

  task automatic t_rate(input int n, input int k);
    int c, per;
    per = (1 << (n + 1)) * (k + 16);
    en = 1'b0; sel = 1'b0; presc = 3'(n); div = 4'(k);
    @(negedge clk);
    en = 1'b1;
    wait_tick(per + 10, c);
    chk($sformatf("R3 first tick n=%0d k=%0d", n, k), c, per);
    @(negedge clk);
    chk("R8 tick width", int'(tick), 0);
    wait_tick(per + 10, c);
    chk($sformatf("R2 period n=%0d k=%0d", n, k), c + 1, per);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable();
    int c, s;
    presc = 3'd0; div = 4'd0; sel = 1'b0; en = 1'b1;
    wait_tick(40, c);
    repeat (10) @(negedge clk);
    en = 1'b0;
    no_tick(100, s);
    chk("R4 no tick while disabled", s, 0);
    en = 1'b1;
    wait_tick(50, c);
    chk("R4 restart full period", c, 32);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_err();
    int c, s;
    presc = 3'd0; div = 4'd0; en = 1'b1;
    repeat (7) @(negedge clk);
    div = 4'd15;
    @(negedge clk);
    chk("R5 err raised", int'(err), 1);
    no_tick(200, s);
    chk("R5 no tick on bad code", s, 0);
    div = 4'd2;
    wait_tick(60, c);
    chk("R5 restart after bad code", c, 36);
    chk("R5 err cleared", int'(err), 0);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ext();
    int c, s;
    presc = 3'd0; div = 4'd0; sel = 1'b1;
    ext_run = 1'b1; en = 1'b1;
    wait_tick(400, c);
    wait_tick(400, c);
    chk("R6 external period", c, 192);
    ext_run = 1'b0;
    wait_tick(400, c);
    no_tick(400, s);
    chk("R6 no tick without pin edges", s, 0);
    en = 1'b0; sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_cfg_change();
    int c;
    presc = 3'd0; div = 4'd0; sel = 1'b0; en = 1'b1;
    wait_tick(40, c);
    repeat (10) @(negedge clk);
    div = 4'd4;
    wait_tick(60, c);
    chk("R7 current period kept", c + 10, 32);
    wait_tick(60, c);
    chk("R7 new period applied", c, 40);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    wd_fired = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(0, 0);
    t_rate(0, 14);
    t_rate(3, 5);
    t_rate(7, 14);
    t_disable();
    t_err();
    t_ext();
    t_cfg_change();
    if (!wd_fired) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule